// File: doc/BRIEF.md
# Directory Coherence Controller

This block sits next to main memory and keeps, for each memory line, a directory entry: the line's global state, a bit per cache port marking which caches hold a copy, and the identity of the owner when one cache holds the line for writing. Caches send it read misses, ownership requests (a cache must ask for ownership before it writes) and release reports (a cache dropping its copy). The controller sends invalidate and write-back commands to the caches that hold the line. It collects their replies, updates the directory and the small data array, and answers every request with one grant message.

Requests are handled one at a time. While a transaction waits for acknowledgments or a write-back, the request input is not ready, so any request, for the same line or another one, waits its turn. Because of this, each line is serialized without a separate busy table.

Top module: `dir_coh_ctrl`

## Requirements
- R1: After reset every line is uncached and its data word is zero. `req_ready_o` is high, and no grant or command is asserted.
- R2: A read request (`req_kind_i` = 0) to a line that is uncached, or shared without an owner, is granted shared (`gnt_excl_o` = 0) with the memory word. The grant appears in the second cycle after the accepting edge, and the requester is then recorded as a holder.
- R3: An ownership request (`req_kind_i` = 1) to a line that no other cache holds is granted exclusive with the memory word, with no command and the same latency as R2. The requester becomes the owner.
- R4: An ownership request to a line that other caches share sends one invalidate pulse on `cmd_inv_o`. The pulse has a bit for each other holder and never the requester's bit. It appears in the second cycle after acceptance, with the line on `cmd_line_o`.
- R5: The exclusive grant for R4 is withheld until every invalidated cache has pulsed its bit on `inv_ack_i`. It appears the cycle after the edge that samples the last acknowledgment. Afterwards the requester is the only holder.
- R6: A read of a line owned by another cache sends a one-cycle write-back command on `cmd_wb_o` to the owner only. When `wb_valid_i` is sampled, the word on `wb_data_i` is written to memory and granted shared in the following cycle. The former owner and the requester then both share the line.
- R7: An ownership request to a line owned by another cache also commands a write-back from the owner. The requester then gets an exclusive grant carrying the written-back word, and the former owner no longer holds the line.
- R8: A release request (`req_kind_i` = 2) removes the requester's copy. If the requester was the owner, `req_data_i` is written to memory. When no holder remains, the line becomes uncached. A release from a cache that does not hold the line changes nothing. Either way it is granted with `gnt_excl_o` = 0.
- R9: A read by the line's own owner is granted exclusive at once with the memory word and leaves the directory unchanged.
- R10: `req_ready_o` is low from the accepting edge until the grant is issued. Each accepted request gets exactly one single-cycle grant naming its port and line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_port_i | input | 2 | Requesting cache port |
| req_kind_i | input | 2 | 0 read, 1 ownership, 2 release |
| req_line_i | input | 4 | Line index |
| req_data_i | input | 32 | Dirty data carried by an owner's release |
| cmd_inv_o | output | 4 | Invalidate pulse, one bit per cache |
| cmd_wb_o | output | 4 | Write-back pulse to the owner |
| cmd_line_o | output | 4 | Line addressed by the command |
| inv_ack_i | input | 4 | Invalidate acknowledgments, one bit per cache |
| wb_valid_i | input | 1 | Write-back data present |
| wb_data_i | input | 32 | Write-back data |
| gnt_valid_o | output | 1 | Grant pulse |
| gnt_port_o | output | 2 | Port being answered |
| gnt_excl_o | output | 1 | 1 exclusive, 0 shared or release |
| gnt_line_o | output | 4 | Line being answered |
| gnt_data_o | output | 32 | Line data (zero for releases) |

## Verification
Requests that need no other cache are granted, and commands are pulsed, in the second cycle after the accepting edge. The bench samples on the falling edge of exactly that cycle, and it also confirms that ready is low in the cycle between. After an invalidate, the bench staggers the acknowledgments over random delays. At each falling edge before the last acknowledgment it checks that no grant has appeared, and it expects the grant on the falling edge right after the edge that samples the last one. A write-back grant is likewise expected in the cycle after the edge that samples `wb_valid_i`. A bench-side directory mirror predicts each command mask, grant type and data word.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {REQ_READ = 2'd0, REQ_OWN = 2'd1, REQ_DROP = 2'd2} req_kind_e;
  typedef enum logic [1:0] {LN_NONE = 2'd0, LN_SHARED = 2'd1, LN_OWNED = 2'd2} line_state_e;
  typedef enum logic [1:0] {FS_IDLE, FS_DECIDE, FS_WAIT_ACK, FS_WAIT_WB} fsm_state_e;
endpackage

// File: rtl/dcc_dir_store.sv
module dcc_dir_store
  import dcc_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_LINES = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(N_LINES)-1:0] rd_idx_i,
  output line_state_e              rd_state_o,
  output logic [N_PORTS-1:0]       rd_sharers_o,
  output logic [((N_PORTS>1)?$clog2(N_PORTS):1)-1:0] rd_owner_o,
  input  logic                     wr_en_i,
  input  logic [$clog2(N_LINES)-1:0] wr_idx_i,
  input  line_state_e              wr_state_i,
  input  logic [N_PORTS-1:0]       wr_sharers_i,
  input  logic [((N_PORTS>1)?$clog2(N_PORTS):1)-1:0] wr_owner_i
);
  localparam int LINE_W = $clog2(N_LINES);
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

  line_state_e        st_arr  [N_LINES];
  logic [N_PORTS-1:0] sh_arr  [N_LINES];
  logic [PORT_W-1:0]  own_arr [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_entry
    line_state_e        st_q;
    logic [N_PORTS-1:0] sh_q;
    logic [PORT_W-1:0]  own_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q  <= LN_NONE;
        sh_q  <= '0;
        own_q <= '0;
      end else if (wr_en_i && wr_idx_i == LINE_W'(g)) begin
        st_q  <= wr_state_i;
        sh_q  <= wr_sharers_i;
        own_q <= wr_owner_i;
      end
    end
    assign st_arr[g]  = st_q;
    assign sh_arr[g]  = sh_q;
    assign own_arr[g] = own_q;
  end

  assign rd_state_o   = st_arr[rd_idx_i];
  assign rd_sharers_o = sh_arr[rd_idx_i];
  assign rd_owner_o   = own_arr[rd_idx_i];

  AST_OWNED_ONE_HOLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_state_i == LN_OWNED) |-> ($countones(wr_sharers_i) == 1 && wr_sharers_i[wr_owner_i])); // R7
  AST_NONE_NO_HOLDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_state_i == LN_NONE) |-> (wr_sharers_i == '0)); // R8
endmodule

// File: rtl/dcc_mem.sv
module dcc_mem #(
  parameter int N_LINES = 16,
  parameter int DATA_W  = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [$clog2(N_LINES)-1:0] rd_idx_i,
  output logic [DATA_W-1:0]          rd_data_o,
  input  logic                       wr_en_i,
  input  logic [$clog2(N_LINES)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i
);
  localparam int LINE_W = $clog2(N_LINES);

  logic [DATA_W-1:0] word_arr [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     word_q <= '0;
      else if (wr_en_i && wr_idx_i == LINE_W'(g))      word_q <= wr_data_i;
    end
    assign word_arr[g] = word_q;
  end

  assign rd_data_o = word_arr[rd_idx_i];
endmodule

// File: rtl/dcc_ack_track.sv
module dcc_ack_track #(
  parameter int N_PORTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N_PORTS-1:0] load_mask_i,
  input  logic [N_PORTS-1:0] ack_i,
  output logic [N_PORTS-1:0] pending_o,
  output logic               done_o
);
  logic [N_PORTS-1:0] pending_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pending_q <= '0;
    else if (load_i) pending_q <= load_mask_i;
    else             pending_q <= pending_q & ~ack_i;
  end

  assign pending_o = pending_q;
  // all outstanding bits clear once this cycle's acks are taken
  assign done_o    = (pending_q & ~ack_i) == '0;

  AST_ACK_EXPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0) |-> ((ack_i & ~pending_q) == '0)); // R5
endmodule

// File: rtl/dir_coh_ctrl.sv
module dir_coh_ctrl
  import dcc_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_LINES = 16,
  parameter int DATA_W  = 32,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [PORT_W-1:0]  req_port_i,
  input  logic [1:0]         req_kind_i,
  input  logic [LINE_W-1:0]  req_line_i,
  input  logic [DATA_W-1:0]  req_data_i,
  output logic [N_PORTS-1:0] cmd_inv_o,
  output logic [N_PORTS-1:0] cmd_wb_o,
  output logic [LINE_W-1:0]  cmd_line_o,
  input  logic [N_PORTS-1:0] inv_ack_i,
  input  logic               wb_valid_i,
  input  logic [DATA_W-1:0]  wb_data_i,
  output logic               gnt_valid_o,
  output logic [PORT_W-1:0]  gnt_port_o,
  output logic               gnt_excl_o,
  output logic [LINE_W-1:0]  gnt_line_o,
  output logic [DATA_W-1:0]  gnt_data_o
);
  fsm_state_e        fsm_q, fsm_d;
  logic [PORT_W-1:0] cur_port_q;
  req_kind_e         cur_kind_q;
  logic [LINE_W-1:0] cur_line_q;
  logic [DATA_W-1:0] cur_data_q;

  line_state_e        dir_state;
  logic [N_PORTS-1:0] dir_sharers;
  logic [PORT_W-1:0]  dir_owner;
  logic               dir_we;
  line_state_e        dir_wst;
  logic [N_PORTS-1:0] dir_wsh;
  logic [PORT_W-1:0]  dir_wown;

  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;

  logic               trk_load;
  logic [N_PORTS-1:0] trk_pending;
  logic               trk_done;

  logic               gnt_set, gnt_excl_d;
  logic [DATA_W-1:0]  gnt_data_d;
  logic [N_PORTS-1:0] inv_d, wb_d;

  logic               gnt_valid_q, gnt_excl_q;
  logic [PORT_W-1:0]  gnt_port_q;
  logic [LINE_W-1:0]  gnt_line_q;
  logic [DATA_W-1:0]  gnt_data_q;
  logic [N_PORTS-1:0] cmd_inv_q, cmd_wb_q;
  logic [LINE_W-1:0]  cmd_line_q;

  logic               accept;
  logic [N_PORTS-1:0] self_mask, owner_mask, others;
  logic               owned_by_other;

  dcc_dir_store #(.N_PORTS(N_PORTS), .N_LINES(N_LINES)) i_dir (
    .clk_i, .rst_ni,
    .rd_idx_i(cur_line_q), .rd_state_o(dir_state), .rd_sharers_o(dir_sharers), .rd_owner_o(dir_owner),
    .wr_en_i(dir_we), .wr_idx_i(cur_line_q), .wr_state_i(dir_wst), .wr_sharers_i(dir_wsh),
    .wr_owner_i(dir_wown)
  );

  dcc_mem #(.N_LINES(N_LINES), .DATA_W(DATA_W)) i_mem (
    .clk_i, .rst_ni,
    .rd_idx_i(cur_line_q), .rd_data_o(mem_rdata),
    .wr_en_i(mem_we), .wr_idx_i(cur_line_q), .wr_data_i(mem_wdata)
  );

  dcc_ack_track #(.N_PORTS(N_PORTS)) i_trk (
    .clk_i, .rst_ni,
    .load_i(trk_load), .load_mask_i(inv_d), .ack_i(inv_ack_i),
    .pending_o(trk_pending), .done_o(trk_done)
  );

  assign req_ready_o    = (fsm_q == FS_IDLE);
  assign accept         = req_valid_i && req_ready_o;
  assign self_mask      = N_PORTS'(1) << cur_port_q;
  assign owner_mask     = N_PORTS'(1) << dir_owner;
  assign others         = dir_sharers & ~self_mask;
  assign owned_by_other = (dir_state == LN_OWNED) && (dir_owner != cur_port_q);

  always_comb begin
    fsm_d      = fsm_q;
    dir_we     = 1'b0;
    dir_wst    = dir_state;
    dir_wsh    = dir_sharers;
    dir_wown   = dir_owner;
    mem_we     = 1'b0;
    mem_wdata  = wb_data_i;
    trk_load   = 1'b0;
    gnt_set    = 1'b0;
    gnt_excl_d = 1'b0;
    gnt_data_d = mem_rdata;
    inv_d      = '0;
    wb_d       = '0;
    unique case (fsm_q)
      FS_IDLE: if (accept) fsm_d = FS_DECIDE;
      FS_DECIDE: begin
        fsm_d = FS_IDLE;
        unique case (cur_kind_q)
          REQ_READ: begin
            if (owned_by_other) begin
              wb_d  = owner_mask;
              fsm_d = FS_WAIT_WB;
            end else if (dir_state == LN_OWNED) begin
              gnt_set    = 1'b1;
              gnt_excl_d = 1'b1;
            end else begin
              gnt_set  = 1'b1;
              dir_we   = 1'b1;
              dir_wst  = LN_SHARED;
              dir_wsh  = dir_sharers | self_mask;
              dir_wown = '0;
            end
          end
          REQ_OWN: begin
            if (owned_by_other) begin
              wb_d  = owner_mask;
              fsm_d = FS_WAIT_WB;
            end else if (others != '0) begin
              inv_d    = others;
              trk_load = 1'b1;
              fsm_d    = FS_WAIT_ACK;
            end else begin
              gnt_set    = 1'b1;
              gnt_excl_d = 1'b1;
              dir_we     = 1'b1;
              dir_wst    = LN_OWNED;
              dir_wsh    = self_mask;
              dir_wown   = cur_port_q;
            end
          end
          default: begin
            gnt_set    = 1'b1;
            gnt_data_d = '0;
            if ((dir_sharers & self_mask) != '0) begin
              dir_we   = 1'b1;
              dir_wsh  = others;
              dir_wst  = (others == '0) ? LN_NONE : LN_SHARED;
              dir_wown = '0;
              if (dir_state == LN_OWNED) begin
                mem_we    = 1'b1;
                mem_wdata = cur_data_q;
              end
            end
          end
        endcase
      end
      FS_WAIT_ACK: begin
        if (trk_done) begin
          fsm_d      = FS_IDLE;
          gnt_set    = 1'b1;
          gnt_excl_d = 1'b1;
          dir_we     = 1'b1;
          dir_wst    = LN_OWNED;
          dir_wsh    = self_mask;
          dir_wown   = cur_port_q;
        end
      end
      default: begin
        if (wb_valid_i) begin
          fsm_d      = FS_IDLE;
          gnt_set    = 1'b1;
          gnt_data_d = wb_data_i;
          mem_we     = 1'b1;
          dir_we     = 1'b1;
          if (cur_kind_q == REQ_READ) begin
            dir_wst  = LN_SHARED;
            dir_wsh  = self_mask | owner_mask;
            dir_wown = '0;
          end else begin
            gnt_excl_d = 1'b1;
            dir_wst    = LN_OWNED;
            dir_wsh    = self_mask;
            dir_wown   = cur_port_q;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= FS_IDLE;
      cur_port_q <= '0;
      cur_kind_q <= REQ_READ;
      cur_line_q <= '0;
      cur_data_q <= '0;
    end else begin
      fsm_q <= fsm_d;
      if (accept) begin
        cur_port_q <= req_port_i;
        cur_kind_q <= req_kind_e'(req_kind_i);
        cur_line_q <= req_line_i;
        cur_data_q <= req_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_valid_q <= 1'b0;
      gnt_excl_q  <= 1'b0;
      gnt_port_q  <= '0;
      gnt_line_q  <= '0;
      gnt_data_q  <= '0;
      cmd_inv_q   <= '0;
      cmd_wb_q    <= '0;
      cmd_line_q  <= '0;
    end else begin
      gnt_valid_q <= gnt_set;
      cmd_inv_q   <= inv_d;
      cmd_wb_q    <= wb_d;
      if (gnt_set) begin
        gnt_excl_q <= gnt_excl_d;
        gnt_port_q <= cur_port_q;
        gnt_line_q <= cur_line_q;
        gnt_data_q <= gnt_data_d;
      end
      if (inv_d != '0 || wb_d != '0) cmd_line_q <= cur_line_q;
    end
  end

  assign gnt_valid_o = gnt_valid_q;
  assign gnt_excl_o  = gnt_excl_q;
  assign gnt_port_o  = gnt_port_q;
  assign gnt_line_o  = gnt_line_q;
  assign gnt_data_o  = gnt_data_q;
  assign cmd_inv_o   = cmd_inv_q;
  assign cmd_wb_o    = cmd_wb_q;
  assign cmd_line_o  = cmd_line_q;

  AST_GNT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |=> !gnt_valid_o); // R10
  AST_EXCL_AFTER_ACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && gnt_excl_o) |-> (trk_pending == '0)); // R5
  AST_INV_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_inv_o != '0) |=> (cmd_inv_o == '0)); // R4
  AST_INV_NOT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_inv_o != '0) |-> ((cmd_inv_o & self_mask) == '0)); // R4
  AST_WB_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wb_o != '0) |-> ($countones(cmd_wb_o) == 1)); // R6
  AST_WB_WHEN_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |-> (fsm_q == FS_WAIT_WB)); // R6
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == FS_WAIT_ACK || fsm_q == FS_WAIT_WB) |-> !gnt_valid_o || $past(fsm_q) == FS_IDLE); // R10
endmodule

// File: tb/test_dir_coh_ctrl.sv
module test_dir_coh_ctrl;
  localparam int NP = 4;
  localparam int NL = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_port = '0;
  logic [1:0]    req_kind = '0;
  logic [3:0]    req_line = '0;
  logic [DW-1:0] req_data = '0;
  logic [NP-1:0] cmd_inv, cmd_wb;
  logic [3:0]    cmd_line;
  logic [NP-1:0] inv_ack = '0;
  logic          wb_valid = 1'b0;
  logic [DW-1:0] wb_data = '0;
  logic          gnt_valid, gnt_excl;
  logic [1:0]    gnt_port;
  logic [3:0]    gnt_line;
  logic [DW-1:0] gnt_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  // bench mirror: state 0 none, 1 shared, 2 owned
  int            m_st  [NL];
  logic [NP-1:0] m_sh  [NL];
  int            m_own [NL];
  logic [DW-1:0] m_mem [NL];

  always #10 clk = ~clk;

  dir_coh_ctrl i_dir_coh_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_port_i(req_port),
    .req_kind_i(req_kind), .req_line_i(req_line), .req_data_i(req_data),
    .cmd_inv_o(cmd_inv), .cmd_wb_o(cmd_wb), .cmd_line_o(cmd_line),
    .inv_ack_i(inv_ack), .wb_valid_i(wb_valid), .wb_data_i(wb_data),
    .gnt_valid_o(gnt_valid), .gnt_port_o(gnt_port), .gnt_excl_o(gnt_excl),
    .gnt_line_o(gnt_line), .gnt_data_o(gnt_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_grant(input int port, input int line, input bit excl,
                           input logic [DW-1:0] data, input bit chk_data, input string tag);
    chk(gnt_valid === 1'b1, {tag, " grant valid"}, 64'(gnt_valid), 1);
    chk(gnt_port == 2'(port) && gnt_line == 4'(line), {tag, " grant port/line"},
        64'({gnt_port, gnt_line}), 64'({2'(port), 4'(line)}));
    chk(gnt_excl == excl, {tag, " grant excl"}, 64'(gnt_excl), 64'(excl));
    if (chk_data) chk(gnt_data == data, {tag, " grant data"}, 64'(gnt_data), 64'(data));
  endtask

  task automatic run_req(input int port, input int kind, input int line, input logic [DW-1:0] data);
    logic [NP-1:0] self, exp_inv, exp_wb;
    logic [DW-1:0] wbd, exp_data;
    bit            exp_excl;
    string         tg;
    int            dly [NP];
    int            maxd;
    self     = NP'(1) << port;
    exp_inv  = '0;
    exp_wb   = '0;
    exp_excl = 1'b0;
    exp_data = m_mem[line];
    wbd      = $urandom;
    tg = (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R8";
    if (kind == 0) begin
      if (m_st[line] == 2 && m_own[line] != port) begin
        tg = "R6"; exp_wb = NP'(1) << m_own[line]; exp_data = wbd;
        m_sh[line] = self | exp_wb; m_st[line] = 1; m_mem[line] = wbd;
      end else if (m_st[line] == 2) begin
        tg = "R9"; exp_excl = 1'b1;
      end else begin
        m_st[line] = 1; m_sh[line] |= self;
      end
    end else if (kind == 1) begin
      exp_excl = 1'b1;
      if (m_st[line] == 2 && m_own[line] != port) begin
        tg = "R7"; exp_wb = NP'(1) << m_own[line]; exp_data = wbd; m_mem[line] = wbd;
      end else if ((m_sh[line] & ~self) != '0) begin
        tg = "R5"; exp_inv = m_sh[line] & ~self;
      end
      m_st[line] = 2; m_sh[line] = self; m_own[line] = port;
    end else begin
      exp_data = '0;
      if ((m_sh[line] & self) != '0) begin
        if (m_st[line] == 2) m_mem[line] = data;
        m_sh[line] &= ~self;
        m_st[line] = (m_sh[line] == '0) ? 0 : 1;
      end
    end
    // drive request
    chk(req_ready === 1'b1, "R10 ready before request", 64'(req_ready), 1);
    req_valid = 1'b1; req_port = 2'(port); req_kind = 2'(kind);
    req_line = 4'(line); req_data = data;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0 && gnt_valid === 1'b0, "R10 busy after accept",
        64'({req_ready, gnt_valid}), 0);
    @(negedge clk);
    chk(cmd_inv == exp_inv, {tag_or(tg, "R4"), " invalidate mask"}, 64'(cmd_inv), 64'(exp_inv));
    chk(cmd_wb == exp_wb, {tg, " write-back mask"}, 64'(cmd_wb), 64'(exp_wb));
    if (exp_inv != '0) begin
      chk(cmd_line == 4'(line) && gnt_valid === 1'b0, "R4 command line", 64'({gnt_valid, cmd_line}), 64'(line));
      maxd = 0;
      for (int p = 0; p < NP; p++) begin
        dly[p] = $urandom_range(0, 3);
        if (exp_inv[p] && dly[p] > maxd) maxd = dly[p];
      end
      for (int t = 0; t <= maxd; t++) begin
        for (int p = 0; p < NP; p++) inv_ack[p] = exp_inv[p] && dly[p] == t;
        @(negedge clk);
        inv_ack = '0;
        if (t < maxd) chk(gnt_valid === 1'b0, "R5 grant withheld", 64'(gnt_valid), 0);
      end
    end else if (exp_wb != '0) begin
      chk(cmd_line == 4'(line) && gnt_valid === 1'b0, "R6 command line", 64'({gnt_valid, cmd_line}), 64'(line));
      maxd = $urandom_range(0, 2);
      for (int t = 0; t < maxd; t++) begin
        @(negedge clk);
        chk(gnt_valid === 1'b0 && cmd_wb == '0, "R6 grant waits for data", 64'({gnt_valid, cmd_wb}), 0);
      end
      wb_valid = 1'b1; wb_data = wbd;
      @(negedge clk);
      wb_valid = 1'b0;
    end
    chk_grant(port, line, exp_excl, exp_data, kind != 2, tg);
  endtask

  function automatic string tag_or(input string a, input string b);
    return (a == "R5") ? b : a;
  endfunction

  initial begin
    for (int l = 0; l < NL; l++) begin
      m_st[l] = 0; m_sh[l] = '0; m_own[l] = 0; m_mem[l] = '0;
    end
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(gnt_valid === 1'b0 && cmd_inv === '0 && cmd_wb === '0, "R1 outputs in reset",
        64'({gnt_valid, cmd_inv, cmd_wb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 1);
    // directed
    run_req(0, 0, 1, '0);            // R1 R2 zero data, shared
    run_req(1, 0, 1, '0);            // R2 second sharer
    run_req(2, 1, 1, '0);            // R4 R5 invalidate 0,1
    run_req(3, 0, 1, '0);            // R6 write-back from 2
    run_req(0, 1, 1, '0);            // R4 invalidates 2 and 3
    run_req(1, 1, 1, '0);            // R7 steal from owner 0
    run_req(1, 2, 1, 32'hCAFE_0001); // R8 owner release writes memory
    run_req(2, 0, 1, '0);            // R8 data reaches memory, line was uncached
    run_req(3, 1, 1, '0);            // R4 invalidates only 2
    run_req(1, 1, 2, '0);            // R3 no holders
    run_req(1, 0, 2, '0);            // R9 owner re-read
    run_req(0, 2, 3, 32'h1234);      // R8 release by non-holder
    run_req(0, 0, 3, '0);            // R8 line 3 unchanged, data zero
    // random
    for (int i = 0; i < 400; i++)
      run_req($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 3), $urandom);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule